// File: doc/BRIEF.md
# HDLC Receive Address Filter and Status

This block sits behind the flag and bit de-stuffing stage of an HDLC receiver. It follows the address field of each received frame and compares it with four programmable address registers. The high address byte is compared against two registers and a fixed broadcast value. The low address byte is compared against two registers that mark command or response frames. When the frame ends, the block either drops the frame without a word, because its address matched nothing, or presents one status byte with a one-cycle valid strobe.

The status byte reports three things. The first is the frame's integrity: overflow, CRC outcome and abort. The second is which high-byte register matched, as a 2-bit code, together with the received command/response bit. The third is which low-byte register matched. A mode input selects one-byte addressing, two-byte addressing or transparent reception. In transparent mode every frame is reported and no address is examined.

Top module: `hdlc_addr_filter`

## Requirements
- R1: `addr_mode` is sampled with the start-of-frame byte. 2'b00 selects one address byte, 2'b01 selects two address bytes (high byte first), and 2'b10 or 2'b11 selects transparent mode with no address bytes.
- R2: In two-byte mode the high byte is compared with `hi_addr1`, then `hi_addr2`, then broadcast, in that priority order. The reported code is 2'b10 for a match on register 1, 2'b00 for register 2 and 2'b01 for broadcast. When both registers hold the same value, a match on that value reports 2'b10.
- R3: Bit 1 of the high byte is the command/response bit and is ignored in every high-byte compare, so 0xFC and 0xFE both match as broadcast.
- R4: The low byte (the only byte in one-byte mode) is compared with `lo_addr1` and `lo_addr2`. The match bit is 1 for register 1 and 0 for register 2, and register 1 wins when both hold the same value.
- R5: The status C/R field copies bit 1 of the received high byte. The C/R field and the high code read 0 outside two-byte mode.
- R6: In transparent mode every frame is reported, and the high code, C/R and low-match fields read 0.
- R7: In one-byte or two-byte mode, a frame whose complete address fails to match produces no status strobe, even if the frame ends with an abort.
- R8: The status byte is {overflow, crc_ok, aborted, hi_code[1:0], cr, lo_match, 0} with bit 7 first. `stat_valid` is high for exactly the one cycle after the cycle holding the end-of-frame or abort strobe. An end strobe outside a frame is ignored.
- R9: For a frame ended by `rx_eof` with a complete address, the crc_ok bit equals `crc_ok_in` in the end cycle.
- R10: The overflow bit is set if `ovf_in` was high in any cycle from the start-of-frame byte to the end strobe. It is cleared for each new frame.
- R11: A frame ended by `rx_abort` whose address matched (or is transparent) is reported with aborted=1 and crc_ok=0.
- R12: A frame that ends before its address field is complete is reported with aborted=1, crc_ok=0 and all address fields 0, in any mode.
- R13: After reset `stat_valid` and `stat_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_sof | input | 1 | First byte of a frame, qualified by `rx_valid` |
| rx_eof | input | 1 | Frame ended normally (cycle without data) |
| rx_abort | input | 1 | Frame aborted by the sender |
| crc_ok_in | input | 1 | CRC result, valid with `rx_eof` |
| ovf_in | input | 1 | Receive overflow seen this cycle |
| addr_mode | input | 2 | Address mode select |
| hi_addr1 | input | 8 | High-byte address register 1 |
| hi_addr2 | input | 8 | High-byte address register 2 |
| lo_addr1 | input | 8 | Low-byte address register 1 (command) |
| lo_addr2 | input | 8 | Low-byte address register 2 (response) |
| stat_byte | output | 8 | Per-frame status |
| stat_valid | output | 1 | Status strobe, one cycle |

## Verification
The assertions check four things on every cycle. Every strobe follows a frame-end event and lasts one cycle. The reserved bit and the high code stay legal. Aborted or truncated frames never show a good CRC. Truncated frames are always reported. Only the bench's scenarios can show that the right register wins a compare: priority between equal registers, masking of the C/R bit, broadcast values, silent dropping of mismatched frames, and overflow being cleared between frames. Each of these depends on the programmed register values and on the bytes received.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  localparam int AF_DW = 8;
  localparam logic [AF_DW-1:0] AF_CR_MASK = 8'hFD;
  localparam logic [AF_DW-1:0] AF_BCAST   = 8'hFC;

  typedef enum logic [1:0] {AF_ONE = 2'b00, AF_TWO = 2'b01, AF_TRN = 2'b10} af_mode_e;

  localparam logic [1:0] HI_CODE_R1 = 2'b10;
  localparam logic [1:0] HI_CODE_R2 = 2'b00;
  localparam logic [1:0] HI_CODE_BC = 2'b01;

  function automatic af_mode_e mode_decode(input logic [1:0] m);
    case (m)
      2'b00:   return AF_ONE;
      2'b01:   return AF_TWO;
      default: return AF_TRN;
    endcase
  endfunction

  function automatic logic [1:0] addr_len(input af_mode_e m);
    case (m)
      AF_ONE:  return 2'd1;
      AF_TWO:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic hi_equal(input logic [AF_DW-1:0] a, input logic [AF_DW-1:0] b);
    return ((a ^ b) & AF_CR_MASK) == '0;
  endfunction
endpackage

// File: rtl/hdlc_af_hi_match.sv
module hdlc_af_hi_match
  import hdlc_af_pkg::*;
#(
  parameter int DW = AF_DW
) (
  input  logic [DW-1:0] hi_byte,
  input  logic [DW-1:0] reg1,
  input  logic [DW-1:0] reg2,
  output logic          hit,
  output logic [1:0]    code,
  output logic          cr
);
  logic m1, m2, mb;

  assign m1 = hi_equal(hi_byte, reg1);
  assign m2 = hi_equal(hi_byte, reg2);
  assign mb = hi_equal(hi_byte, AF_BCAST);
  assign cr = hi_byte[1];
  assign hit = m1 | m2 | mb;

  always_comb begin
    if (m1)      code = HI_CODE_R1;
    else if (m2) code = HI_CODE_R2;
    else         code = HI_CODE_BC;
  end
endmodule

// File: rtl/hdlc_af_lo_match.sv
module hdlc_af_lo_match
  import hdlc_af_pkg::*;
#(
  parameter int DW = AF_DW
) (
  input  logic [DW-1:0] lo_byte,
  input  logic [DW-1:0] reg1,
  input  logic [DW-1:0] reg2,
  output logic          hit,
  output logic          sel1
);
  logic m1, m2;

  assign m1   = (lo_byte == reg1);
  assign m2   = (lo_byte == reg2);
  assign hit  = m1 | m2;
  assign sel1 = m1;
endmodule

// File: rtl/hdlc_af_status.sv
module hdlc_af_status (
  input  logic       ovf,
  input  logic       crc_ok,
  input  logic       aborted,
  input  logic [1:0] hi_code,
  input  logic       cr,
  input  logic       lo_sel,
  output logic [7:0] status
);
  assign status = {ovf, crc_ok, aborted, hi_code, cr, lo_sel, 1'b0};
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int DW = AF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_abort,
  input  logic          crc_ok_in,
  input  logic          ovf_in,
  input  logic [1:0]    addr_mode,
  input  logic [DW-1:0] hi_addr1,
  input  logic [DW-1:0] hi_addr2,
  input  logic [DW-1:0] lo_addr1,
  input  logic [DW-1:0] lo_addr2,
  output logic [7:0]    stat_byte,
  output logic          stat_valid
);
  localparam logic [1:0] CNT_MAX = 2'd3;

  logic       in_frame;
  logic [1:0] cnt;
  af_mode_e   mode_q;
  logic       hi_hit_q, cr_q, lo_hit_q, lo_sel_q, ovf_q;
  logic [1:0] hi_code_q;

  // named events, used by the checker
  logic       byte_evt, end_evt, addr_done, addr_ok, emit;
  logic       hi_take, lo_take;
  af_mode_e   cur_mode;
  logic [1:0] idx, need;

  logic       hi_hit, hi_cr, lo_hit, lo_sel;
  logic [1:0] hi_code;
  logic       f_ovf, f_crc, f_abort, f_cr, f_lo;
  logic [1:0] f_hi;
  logic [7:0] status_nx;

  assign byte_evt = rx_valid && (rx_sof || in_frame);
  assign cur_mode = rx_sof ? mode_decode(addr_mode) : mode_q;
  assign idx      = rx_sof ? 2'd0 : cnt;
  assign need     = addr_len(cur_mode);
  assign hi_take  = byte_evt && (cur_mode == AF_TWO) && (idx == 2'd0);
  assign lo_take  = byte_evt && (need != 2'd0) && (idx == 2'(need - 2'd1));

  hdlc_af_hi_match #(.DW(DW)) u_hi (
    .hi_byte(rx_data), .reg1(hi_addr1), .reg2(hi_addr2),
    .hit(hi_hit), .code(hi_code), .cr(hi_cr)
  );

  hdlc_af_lo_match #(.DW(DW)) u_lo (
    .lo_byte(rx_data), .reg1(lo_addr1), .reg2(lo_addr2),
    .hit(lo_hit), .sel1(lo_sel)
  );

  assign end_evt   = in_frame && (rx_eof || rx_abort) && !rx_sof;
  assign addr_done = cnt >= addr_len(mode_q);
  assign addr_ok   = (mode_q == AF_TRN) ||
                     (lo_hit_q && ((mode_q == AF_ONE) || hi_hit_q));
  assign emit      = end_evt && (!addr_done || addr_ok);

  assign f_ovf   = ovf_q | ovf_in;
  assign f_abort = rx_abort || !addr_done;
  assign f_crc   = crc_ok_in && !f_abort;
  assign f_hi    = (addr_done && mode_q == AF_TWO) ? hi_code_q : 2'b00;
  assign f_cr    = addr_done && (mode_q == AF_TWO) && cr_q;
  assign f_lo    = addr_done && (mode_q != AF_TRN) && lo_sel_q;

  hdlc_af_status u_stat (
    .ovf(f_ovf), .crc_ok(f_crc), .aborted(f_abort),
    .hi_code(f_hi), .cr(f_cr), .lo_sel(f_lo), .status(status_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      cnt       <= 2'd0;
      mode_q    <= AF_ONE;
      ovf_q     <= 1'b0;
      hi_hit_q  <= 1'b0;
      hi_code_q <= 2'b00;
      cr_q      <= 1'b0;
      lo_hit_q  <= 1'b0;
      lo_sel_q  <= 1'b0;
    end else begin
      if (byte_evt && rx_sof) begin
        in_frame <= 1'b1;
        cnt      <= 2'd1;
        mode_q   <= cur_mode;
        ovf_q    <= ovf_in;
      end else if (end_evt) begin
        in_frame <= 1'b0;
      end else if (in_frame) begin
        ovf_q <= ovf_q | ovf_in;
        if (byte_evt && cnt != CNT_MAX) cnt <= cnt + 2'd1;
      end

      if (hi_take) begin
        hi_hit_q  <= hi_hit;
        hi_code_q <= hi_code;
        cr_q      <= hi_cr;
      end else if (byte_evt && rx_sof) begin
        hi_hit_q  <= 1'b0;
        hi_code_q <= 2'b00;
        cr_q      <= 1'b0;
      end

      if (lo_take) begin
        lo_hit_q <= lo_hit;
        lo_sel_q <= lo_sel;
      end else if (byte_evt && rx_sof) begin
        lo_hit_q <= 1'b0;
        lo_sel_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_byte  <= 8'h00;
    end else begin
      stat_valid <= emit;
      if (emit) stat_byte <= status_nx;
    end
  end
endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_abort,
  input logic       end_evt,
  input logic       emit,
  input logic       addr_done,
  input logic       stat_valid,
  input logic [7:0] stat_byte
);
  p_strobe_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(end_evt));

  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_byte[0] == 1'b0));

  p_hicode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_byte[4:3] != 2'b11));

  p_abort_no_crc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_byte[5]) |-> !stat_byte[6]);

  p_abort_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && rx_abort) |=> (stat_valid && stat_byte[5]));

  p_short_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !addr_done) |=> (stat_valid && stat_byte[5] && !stat_byte[6]
                                 && stat_byte[4:1] == 4'b0000));
endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_abort(rx_abort), .end_evt(end_evt),
  .emit(emit), .addr_done(addr_done), .stat_valid(stat_valid), .stat_byte(stat_byte)
);

// File: tb/hdlc_addr_filter_tb.sv
module hdlc_addr_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_abort = 1'b0;
  logic       crc_ok_in = 1'b0, ovf_in = 1'b0;
  logic [1:0] addr_mode = 2'b00;
  logic [7:0] hi_addr1 = 8'h10, hi_addr2 = 8'h24, lo_addr1 = 8'h01, lo_addr2 = 8'h03;
  logic [7:0] stat_byte;
  logic       stat_valid;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  hdlc_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_abort(rx_abort), .crc_ok_in(crc_ok_in),
    .ovf_in(ovf_in), .addr_mode(addr_mode), .hi_addr1(hi_addr1), .hi_addr2(hi_addr2),
    .lo_addr1(lo_addr1), .lo_addr2(lo_addr2), .stat_byte(stat_byte), .stat_valid(stat_valid)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] b0, b1, b2;
    logic [1:0] nb;
    logic       ab, crc, ovf, ev;
    logic [7:0] es;
    logic [31:0] req;
  } vec_t;

  // status = {ovf, crc_ok, aborted, hi_code[1:0], cr, lo_match, 0}
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h10, 8'h01, 8'hAA, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h52, "R2"},
    '{2'd1, 8'h12, 8'h03, 8'hAA, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h54, "R3"},
    '{2'd1, 8'h24, 8'h01, 8'hAA, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h82, "R10"},
    '{2'd1, 8'hFE, 8'h03, 8'hAA, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h4C, "R3"},
    '{2'd1, 8'hFC, 8'h01, 8'hAA, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'h4A, "R5"},
    '{2'd1, 8'h55, 8'h01, 8'hAA, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7"},
    '{2'd1, 8'h10, 8'h77, 8'hAA, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7"},
    '{2'd0, 8'h01, 8'hAA, 8'hBB, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'h42, "R4"},
    '{2'd0, 8'h03, 8'hAA, 8'hBB, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'h40, "R9"},
    '{2'd0, 8'h10, 8'hAA, 8'hBB, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R1"},
    '{2'd2, 8'h99, 8'hAA, 8'hBB, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h40, "R6"},
    '{2'd1, 8'h10, 8'h01, 8'hAA, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h32, "R11"},
    '{2'd1, 8'h10, 8'hAA, 8'hBB, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h20, "R12"},
    '{2'd0, 8'h55, 8'hAA, 8'hBB, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R7"},
    '{2'd2, 8'h99, 8'hAA, 8'hBB, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA0, "R11"},
    '{2'd3, 8'h77, 8'hAA, 8'hBB, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h40, "R1"}
  };

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Sends one frame; returns strobe/status seen the cycle after the end
  // strobe, and the strobe one cycle later (must be low).
  task automatic send(input logic [1:0] mode, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input int nb, input logic ab, input logic crc,
                      input logic ovf, output logic v, output logic [7:0] s, output logic v2);
    @(negedge clk);
    addr_mode = mode; rx_valid = 1'b1; rx_sof = 1'b1; rx_data = b0; ovf_in = ovf;
    for (int k = 1; k < nb; k++) begin
      @(negedge clk);
      rx_sof = 1'b0; ovf_in = 1'b0; rx_data = (k == 1) ? b1 : b2;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; ovf_in = 1'b0;
    rx_eof = !ab; rx_abort = ab; crc_ok_in = crc;
    @(negedge clk);
    rx_eof = 1'b0; rx_abort = 1'b0; crc_ok_in = 1'b0;
    v = stat_valid; s = stat_byte;
    @(negedge clk);
    v2 = stat_valid;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic v, v2;
    logic [7:0] s;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(stat_valid == 1'b0, "R13", {7'd0, stat_valid}, 8'h00);
    chk(stat_byte == 8'h00, "R13", stat_byte, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].mode, VECS[i].b0, VECS[i].b1, VECS[i].b2, int'(VECS[i].nb),
           VECS[i].ab, VECS[i].crc, VECS[i].ovf, v, s, v2);
      chk(v == VECS[i].ev, $sformatf("%s vec%0d strobe", VECS[i].req, i), {7'd0, v}, {7'd0, VECS[i].ev});
      if (VECS[i].ev)
        chk(s == VECS[i].es, $sformatf("%s vec%0d status", VECS[i].req, i), s, VECS[i].es);
      chk(v2 == 1'b0, $sformatf("R8 vec%0d single-cycle", i), {7'd0, v2}, 8'h00);
    end

    // R2: equal high registers report register-1 code
    hi_addr2 = 8'h10;
    send(2'd1, 8'h10, 8'h01, 8'hAA, 3, 1'b0, 1'b1, 1'b0, v, s, v2);
    chk(v && s == 8'h52, "R2 equal regs", s, 8'h52);
    hi_addr2 = 8'h24;

    // R4: equal low registers report register-1 bit
    lo_addr2 = 8'h01;
    send(2'd0, 8'h01, 8'hAA, 8'hBB, 2, 1'b0, 1'b1, 1'b0, v, s, v2);
    chk(v && s == 8'h42, "R4 equal regs", s, 8'h42);
    lo_addr2 = 8'h03;

    // R8: end strobe outside any frame is ignored
    @(negedge clk); rx_eof = 1'b1; crc_ok_in = 1'b1;
    @(negedge clk); rx_eof = 1'b0; crc_ok_in = 1'b0;
    chk(stat_valid == 1'b0, "R8 stray eof", {7'd0, stat_valid}, 8'h00);

    // R10: overflow cleared for the next frame
    send(2'd0, 8'h03, 8'hAA, 8'hBB, 2, 1'b0, 1'b1, 1'b1, v, s, v2);
    chk(v && s == 8'hC0, "R10 ovf set", s, 8'hC0);
    send(2'd0, 8'h03, 8'hAA, 8'hBB, 2, 1'b0, 1'b1, 1'b0, v, s, v2);
    chk(v && s == 8'h40, "R10 ovf cleared", s, 8'h40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule